// File: doc/BRIEF.md
# Page-Write Byte-Wide EEPROM Emulator

This block is a synthesizable stand-in for a parallel, byte-wide EEPROM that writes a whole page at a time. A host drives an active-low chip select, read strobe and write strobe, an address and a data byte. All of these are sampled on the system clock. Inside the chip the bidirectional data pin is split into an input byte, an output byte and a pad drive enable. The array is organised as pages of 128 bytes. The default build keeps 16 pages so that elaboration stays small. Setting `ADDR_W` to 17 gives the full 1024-page, 128K-byte arrangement.

Writes are guarded. A three-write key sequence must come first, and only then does a page load open. The host then writes bytes into a one-page buffer. Once the host stays quiet for `LOAD_TMO` clocks, the block starts a self-timed program interval of `PROG_CYC` clocks. That interval stands for the nominal 5 ms erase-and-program step. At its end, only the loaded bytes of the page are replaced.

While the interval runs, reads return status instead of data. Bit 7 reads as the inverse of the last accepted byte, and bit 6 flips from one read to the next. The key is consumed by each page load, so every page write needs a fresh key. A write strobe that is already low when reset releases cannot start a write.

Top module: `pagewr_eeprom`

## Requirements
- R1: Address bits [ADDR_W-1:7] name the page and bits [6:0] the byte within it. Within one load, bytes whose page differs from that of the first loaded byte are dropped.
- R2: `dq_oe` is 1 exactly when `ce_n` and `oe_n` are both 0. Otherwise the pad is released.
- R3: After reset every byte reads 0xFF. When no program interval is running, a read returns the stored byte at the presented address.
- R4: A write is taken on the clock where `we_n` is first seen 0 while `ce_n` is 0 and `oe_n` is 1. Address and data are captured in that cycle, so later changes during the same strobe are not used.
- R5: A page load opens only after the writes (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), in that order. Any other write while locked is discarded and leaves the array unchanged. A wrong write restarts the key, counting itself as the first step if it is (0x555, 0xAA).
- R6: A load closes `LOAD_TMO` clocks after the last accepted byte. If bytes were loaded, a program interval of `PROG_CYC` clocks follows. If none were loaded, the block returns to the locked state with no interval.
- R7: At the end of the interval, only the loaded offsets of the page change. Each takes the last value written to it. Other bytes keep their contents.
- R8: During the interval a read returns bit 7 as the inverse of bit 7 of the last accepted byte, and bits [5:0] equal to those of that byte, whatever the address.
- R9: During the interval bit 6 reads 0 on the first read and inverts after every completed read.
- R10: Writes presented during the interval are ignored. After it ends, reads return true array data.
- R11: If `we_n` is held low through reset release, no write is taken until `we_n` has been seen high.
- R12: After a commit the block is locked again. A later write without the key is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array to 0xFF |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low, edge detected |
| addr | input | ADDR_W | Byte address: page in the upper bits, offset in [6:0] |
| dq_in | input | 8 | Data from the pad during writes |
| dq_out | output | 8 | Array byte or polling status during reads |
| dq_oe | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
Several corner cases are targeted.

- **Polling bits.** The status byte is read repeatedly during the program interval, at different addresses. A design that advanced bit 6 on every clock instead of per read would show a changing bit within a read. A design that reported the raw last byte would fail the bit-7 inversion.
- **Page loads.** A load mixes an overwrite of one offset, a byte aimed at the next page, and a write attempted while the page is programming. A design that erased the whole page would show 0xFF where stale data must survive. One that followed the stray page would corrupt a neighbour.
- **Key handling.** A broken key, a key followed by an empty window, and a second page write without a key are each tried. A design that left the lock open after a commit would accept them.
- **Power-up strobe.** A write strobe already low at reset release is tested. A level-triggered write path would accept the first key write.
- **Latching.** Address and data are changed mid-strobe. A design that captured them late would store the wrong byte.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

  localparam int OFS_W      = 7;
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam logic [7:0] ERASED = 8'hFF;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_LOAD = 2'd1,
    CTL_BUSY = 2'd2
  } ctl_state_e;

  function automatic int unsigned page_of(input logic [31:0] a);
    return int'(a >> OFS_W);
  endfunction

  function automatic logic [OFS_W-1:0] ofs_of(input logic [31:0] a);
    return a[OFS_W-1:0];
  endfunction

  // status byte seen on reads while a page is programming
  function automatic logic [7:0] poll_byte(input logic [7:0] last, input logic flip);
    return {~last[7], flip, last[5:0]};
  endfunction

  // data byte expected at each step of the unlock key
  function automatic logic [7:0] key_byte(input logic [1:0] step);
    case (step)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/pwe_bus_front.sv
module pwe_bus_front #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_act,
  output logic              rd_end
);

  logic we_q;
  logic rd_q;
  logic wr_evt;

  assign rd_act = !ce_n && !oe_n;
  assign rd_end = rd_q && !rd_act;
  // we_q clears in reset, so a strobe held low from power-up gives no edge
  assign wr_evt = !ce_n && oe_n && !we_n && we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      we_q   <= we_n;
      rd_q   <= rd_act;
      wr_stb <= wr_evt;
      if (wr_evt) begin
        wr_addr <= addr;
        wr_data <= dq_in;
      end
    end
  end

endmodule

// File: rtl/pwe_unlock.sv
module pwe_unlock #(
  parameter int          ADDR_W = 11,
  parameter int unsigned KEY_A  = 'h555,
  parameter int unsigned KEY_B  = 'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              key_ok
);

  localparam logic [ADDR_W-1:0] KA = ADDR_W'(KEY_A);
  localparam logic [ADDR_W-1:0] KB = ADDR_W'(KEY_B);

  logic [1:0]        step;
  logic [ADDR_W-1:0] want_addr;
  logic              hit;
  logic              restart;
  logic              take;

  assign want_addr = (step == 2'd1) ? KB : KA;
  assign take      = wr_stb && armed;
  assign hit       = take && (wr_addr == want_addr) && (wr_data == pwe_pkg::key_byte(step));
  assign restart   = (wr_addr == KA) && (wr_data == pwe_pkg::key_byte(2'd0));
  assign key_ok    = hit && (step == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= 2'd0;
    end else if (take) begin
      if (hit)
        step <= (step == 2'd2) ? 2'd0 : step + 2'd1;
      else
        step <= restart ? 2'd1 : 2'd0;
    end
  end

endmodule

// File: rtl/pwe_page_ctl.sv
module pwe_page_ctl
  import pwe_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int LOAD_TMO = 64,
  parameter int PROG_CYC = 5000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             key_ok,
  input  logic                             wr_stb,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [7:0]                       wr_data,
  input  logic                             rd_end,
  output logic                             armed,
  output logic                             loading,
  output logic                             busy,
  output logic                             commit,
  output logic [ADDR_W-OFS_W-1:0]          cmt_page,
  output logic [PAGE_BYTES-1:0][7:0]       pbuf,
  output logic [PAGE_BYTES-1:0]            pvalid,
  output logic [7:0]                       last_byte,
  output logic                             tgl
);

  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int TMO_W  = $clog2(LOAD_TMO + 1);
  localparam int PRG_W  = $clog2(PROG_CYC + 1);

  ctl_state_e        st;
  logic [TMO_W-1:0]  quiet;
  logic [PRG_W-1:0]  prog;
  logic              have;
  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] in_page;
  logic [OFS_W-1:0]  in_ofs;
  logic              acc;
  logic              window_end;

  assign in_page    = PAGE_W'(page_of(32'(wr_addr)));
  assign in_ofs     = ofs_of(32'(wr_addr));
  assign acc        = (st == CTL_LOAD) && wr_stb && (!have || in_page == page_q);
  assign window_end = (st == CTL_LOAD) && !acc && (quiet == TMO_W'(LOAD_TMO - 1));
  assign commit     = (st == CTL_BUSY) && (prog == PRG_W'(PROG_CYC - 1));
  assign armed      = (st == CTL_IDLE);
  assign loading    = (st == CTL_LOAD);
  assign busy       = (st == CTL_BUSY);
  assign cmt_page   = page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= CTL_IDLE;
      quiet     <= '0;
      prog      <= '0;
      have      <= 1'b0;
      page_q    <= '0;
      pbuf      <= '0;
      pvalid    <= '0;
      last_byte <= '0;
      tgl       <= 1'b0;
    end else begin
      unique case (st)
        CTL_IDLE: begin
          if (key_ok) begin
            st     <= CTL_LOAD;
            quiet  <= '0;
            have   <= 1'b0;
            pvalid <= '0;
          end
        end
        CTL_LOAD: begin
          if (acc) begin
            quiet          <= '0;
            have           <= 1'b1;
            page_q         <= in_page;
            pbuf[in_ofs]   <= wr_data;
            pvalid[in_ofs] <= 1'b1;
            last_byte      <= wr_data;
          end else if (window_end) begin
            st   <= have ? CTL_BUSY : CTL_IDLE;
            prog <= '0;
            tgl  <= 1'b0;
          end else begin
            quiet <= quiet + 1'b1;
          end
        end
        CTL_BUSY: begin
          if (rd_end) tgl <= ~tgl;
          if (commit) st <= CTL_IDLE;
          else        prog <= prog + 1'b1;
        end
        default: st <= CTL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwe_array.sv
module pwe_array
  import pwe_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  logic [ADDR_W-OFS_W-1:0]    cmt_page,
  input  logic [PAGE_BYTES-1:0][7:0] pbuf,
  input  logic [PAGE_BYTES-1:0]      pvalid,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [7:0]                 rdata
);

  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int PAGES  = 1 << PAGE_W;

  logic [PAGE_W-1:0]            rd_page;
  logic [OFS_W-1:0]             rd_ofs;
  logic [PAGE_BYTES-1:0][7:0]   col_rd;

  assign rd_page = PAGE_W'(page_of(32'(rd_addr)));
  assign rd_ofs  = ofs_of(32'(rd_addr));

  // one column per byte offset; a commit touches only the loaded columns
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_col
    logic [7:0] cells [PAGES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < PAGES; r++) cells[r] <= ERASED;
      end else if (commit && pvalid[i]) begin
        cells[cmt_page] <= pbuf[i];
      end
    end

    assign col_rd[i] = cells[rd_page];
  end

  assign rdata = col_rd[rd_ofs];

endmodule

// File: rtl/pagewr_eeprom.sv
module pagewr_eeprom #(
  parameter int          ADDR_W   = 11,
  parameter int          LOAD_TMO = 64,
  parameter int          PROG_CYC = 5000,
  parameter int unsigned KEY_A    = 'h555,
  parameter int unsigned KEY_B    = 'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);

  localparam int PAGE_W = ADDR_W - pwe_pkg::OFS_W;

  logic                                   wr_stb;
  logic [ADDR_W-1:0]                      wr_addr;
  logic [7:0]                             wr_data;
  logic                                   rd_end;
  logic                                   key_ok;
  logic                                   armed;
  logic                                   st_load;
  logic                                   st_busy;
  logic                                   commit;
  logic [PAGE_W-1:0]                      cmt_page;
  logic [pwe_pkg::PAGE_BYTES-1:0][7:0]    pbuf;
  logic [pwe_pkg::PAGE_BYTES-1:0]         pvalid;
  logic [7:0]                             last_byte;
  logic                                   tgl;
  logic [7:0]                             arr_rd;

  pwe_bus_front #(.ADDR_W(ADDR_W)) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .addr    (addr),
    .dq_in   (dq_in),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_act  (dq_oe),
    .rd_end  (rd_end)
  );

  pwe_unlock #(.ADDR_W(ADDR_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (armed),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .key_ok  (key_ok)
  );

  pwe_page_ctl #(.ADDR_W(ADDR_W), .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_ok    (key_ok),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_end    (rd_end),
    .armed     (armed),
    .loading   (st_load),
    .busy      (st_busy),
    .commit    (commit),
    .cmt_page  (cmt_page),
    .pbuf      (pbuf),
    .pvalid    (pvalid),
    .last_byte (last_byte),
    .tgl       (tgl)
  );

  pwe_array #(.ADDR_W(ADDR_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .cmt_page (cmt_page),
    .pbuf     (pbuf),
    .pvalid   (pvalid),
    .rd_addr  (addr),
    .rdata    (arr_rd)
  );

  assign dq_out = st_busy ? pwe_pkg::poll_byte(last_byte, tgl) : arr_rd;

endmodule

// File: rtl/pagewr_eeprom_chk.sv
module pagewr_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       dq_oe,
  input logic [7:0] dq_out,
  input logic       wr_stb,
  input logic       key_ok,
  input logic       st_load,
  input logic       st_busy,
  input logic       commit,
  input logic       rd_end,
  input logic       tgl,
  input logic [7:0] last_byte
);

  // R2
  pad_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !dq_oe);

  // R4
  wr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(we_n) == 1'b0 && $past(ce_n) == 1'b0 && $past(oe_n) == 1'b1));

  // R5
  load_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_load) |-> $past(key_ok));

  // R6
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_busy) |-> $past(st_load));

  // R10
  commit_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!st_busy && !st_load));

  // R9
  tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && $past(st_busy) && !$past(rd_end)) |-> $stable(tgl));

  // R8
  poll_b7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && dq_oe) |-> (dq_out[7] != last_byte[7]));

endmodule

bind pagewr_eeprom pagewr_eeprom_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .dq_oe     (dq_oe),
  .dq_out    (dq_out),
  .wr_stb    (wr_stb),
  .key_ok    (key_ok),
  .st_load   (st_load),
  .st_busy   (st_busy),
  .commit    (commit),
  .rd_end    (rd_end),
  .tgl       (tgl),
  .last_byte (last_byte)
);

// File: tb/pagewr_eeprom_test.sv
module pagewr_eeprom_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam int LOAD_TMO   = 16;
  localparam int PROG_CYC   = 120;
  localparam int KEY_A      = 'h555;
  localparam int KEY_B      = 'h2AA;
  localparam int PG         = 128;
  localparam int DEPTH      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce_n, oe_n, we_n;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        dq_in;
  logic [7:0]        dq_out;
  logic              dq_oe;

  int tests = 0;
  int fails = 0;

  pagewr_eeprom #(
    .ADDR_W(ADDR_W), .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC),
    .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  byte unsigned ref_mem [DEPTH];
  byte unsigned pend [int];
  int           m_mode;   // 0 locked, 1 loading, 2 programming
  int           m_step, m_quiet, m_left, m_page;
  bit           m_tog, m_weq, m_rdq, m_pv;
  int           m_pa;
  byte unsigned m_pd, m_last;

  function automatic int key_addr(input int s);
    return (s == 1) ? KEY_B : KEY_A;
  endfunction

  function automatic int key_val(input int s);
    return (s == 0) ? 'hAA : (s == 1) ? 'h55 : 'hA0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    pend.delete();
    m_mode = 0; m_step = 0; m_quiet = 0; m_left = 0; m_page = -1;
    m_tog = 0; m_weq = 0; m_rdq = 0; m_pv = 0; m_pa = 0; m_pd = 0; m_last = 0;
  endtask

  task automatic model_step();
    bit           stb;
    int           sa;
    byte unsigned sd;
    bit           rd_now;
    bit           rdone;
    stb = m_pv; sa = m_pa; sd = m_pd;
    rd_now = !ce_n && !oe_n;
    rdone  = m_rdq && !rd_now;
    m_pv   = !ce_n && oe_n && !we_n && m_weq;
    if (m_pv) begin m_pa = int'(addr); m_pd = dq_in; end
    m_weq = we_n;
    m_rdq = rd_now;
    if (m_mode == 0) begin
      if (stb) begin
        if (sa == key_addr(m_step) && int'(sd) == key_val(m_step)) begin
          if (m_step == 2) begin
            m_step = 0; m_mode = 1; m_quiet = 0; m_page = -1; pend.delete();
          end else m_step++;
        end else m_step = (sa == KEY_A && sd == 8'hAA) ? 1 : 0;
      end
    end else if (m_mode == 1) begin
      if (stb && (m_page < 0 || m_page == sa / PG)) begin
        m_page = sa / PG; pend[sa % PG] = sd; m_last = sd; m_quiet = 0;
      end else if (m_quiet == LOAD_TMO - 1) begin
        if (pend.num() > 0) begin m_mode = 2; m_left = PROG_CYC; m_tog = 0; end
        else m_mode = 0;
      end else m_quiet++;
    end else begin
      if (rdone) m_tog = !m_tog;
      m_left--;
      if (m_left == 0) begin
        foreach (pend[o]) ref_mem[m_page * PG + o] = pend[o];
        m_mode = 0;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    logic [7:0] e;
    #1;
    if (rst_n) begin
      tests++;
      if (dq_oe !== (!ce_n && !oe_n)) begin
        fails++;
        $display("FAIL R2 model: dq_oe got %0b expected %0b", dq_oe, !ce_n && !oe_n);
      end
      if (!ce_n && !oe_n) begin
        e = (m_mode == 2) ? {~m_last[7], m_tog, m_last[5:0]} : ref_mem[int'(addr)];
        tests++;
        if (dq_out !== e) begin
          fails++;
          $display("FAIL R3/R8 model at %03h: got %02h expected %02h", addr, dq_out, e);
        end
      end
    end
  end

  // ---------------- directed tasks ----------------
  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; addr = ADDR_W'(a); dq_in = 8'(d); we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = ADDR_W'(a);
    #1 v = dq_out;
    @(negedge clk);
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic key();
    wr(KEY_A, 'hAA);
    wr(KEY_B, 'h55);
    wr(KEY_A, 'hA0);
  endtask

  bit done = 0;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; dq_in = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // reset state
    chk8("R2 reset pad", {7'd0, dq_oe}, 8'h00);
    rd(0, v);          chk8("R3 erased after reset", v, 8'hFF);
    rd('h7FF, v);      chk8("R3 erased top byte", v, 8'hFF);

    // write with no key
    wr('h010, 'h3C);
    idle(LOAD_TMO + 4);
    rd('h010, v);      chk8("R5 keyless write dropped", v, 8'hFF);

    // broken key
    wr(KEY_A, 'hAA); wr(KEY_B, 'h54); wr(KEY_A, 'hA0); wr('h020, 'h11);
    idle(LOAD_TMO + 4);
    rd('h020, v);      chk8("R5 broken key dropped", v, 8'hFF);

    // full page load on page 2
    key();
    wr('h100, 'hA5);
    wr('h105, 'h5A);
    wr('h17F, 'h3C);
    wr('h105, 'hC3);
    wr('h180, 'h99);   // R1: other page, dropped
    idle(LOAD_TMO + 2);
    rd('h100, v);      chk8("R8 poll first read", v, 8'h03);
    rd('h000, v);      chk8("R9 poll second read toggles", v, 8'h43);
    rd('h7FF, v);      chk8("R9 poll third read toggles back", v, 8'h03);
    wr('h101, 'h77);   // R10: during busy, ignored
    rd('h105, v);      chk8("R8 poll bits 5:0", v, 8'h43);
    idle(PROG_CYC + 4);
    rd('h100, v);      chk8("R7 byte committed", v, 8'hA5);
    rd('h105, v);      chk8("R7 last write wins", v, 8'hC3);
    rd('h17F, v);      chk8("R7 top offset committed", v, 8'h3C);
    rd('h101, v);      chk8("R10 busy write ignored", v, 8'hFF);
    rd('h102, v);      chk8("R7 unloaded byte kept", v, 8'hFF);
    rd('h180, v);      chk8("R1 foreign page untouched", v, 8'hFF);

    // relock after commit
    wr('h100, 'h00);
    idle(LOAD_TMO + 4);
    rd('h100, v);      chk8("R12 relocked after commit", v, 8'hA5);

    // key followed by empty window
    key();
    idle(LOAD_TMO + 4);
    rd('h17F, v);      chk8("R6 empty window no busy", v, 8'h3C);
    wr('h100, 'h00);
    idle(LOAD_TMO + 4);
    rd('h100, v);      chk8("R6 lock after empty window", v, 8'hA5);

    // pad release combinations
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    #1 chk8("R2 oe high releases", {7'd0, dq_oe}, 8'h00);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    #1 chk8("R2 ce high releases", {7'd0, dq_oe}, 8'h00);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    #1 chk8("R2 both low drives", {7'd0, dq_oe}, 8'h01);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;

    // write strobe held low across reset
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    addr = ADDR_W'(KEY_A); dq_in = 8'hAA;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    we_n = 1'b1; ce_n = 1'b1;
    idle(1);
    wr(KEY_B, 'h55); wr(KEY_A, 'hA0); wr('h200, 'h66);
    idle(LOAD_TMO + 4);
    rd('h200, v);      chk8("R11 held strobe gives no write", v, 8'hFF);
    rd('h100, v);      chk8("R3 reset erases array", v, 8'hFF);

    // normal write after power-up, with mid-strobe changes
    key();
    wr('h200, 'h66);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; addr = ADDR_W'('h205); dq_in = 8'h12; we_n = 1'b0;
    @(negedge clk);
    addr = ADDR_W'('h206); dq_in = 8'h34;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
    idle(LOAD_TMO + PROG_CYC + 6);
    rd('h200, v);      chk8("R11 write after strobe release", v, 8'h66);
    rd('h205, v);      chk8("R4 data latched at edge", v, 8'h12);
    rd('h206, v);      chk8("R4 late address ignored", v, 8'hFF);

    idle(2);
    done = 1;
    summary();
    $finish;
  end

endmodule